// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast oscillator-rate clock by a programmable integer and emits one single-clock pulse per division cycle, for use by a phase comparator. The divider is built from three cooperating parts. A dual-modulus prescaler divides by a base modulus P or by P+1. A swallow counter keeps the prescaler at P+1 for the first A prescaler cycles of each division cycle. A main counter counts B prescaler cycles and marks the end of the division cycle. The resulting overall ratio is P·B + A. The prescaler is modelled as a synchronous counter running on the divider clock.

The base modulus is 2^K or 2^(K+1), chosen by a select bit. With the defaults this gives 32 or 64; a narrower instance gives 8 or 16. Preset values are sampled only at the boundary between two division cycles, so a period that is running always finishes with the values it started with. Power-down and a counter-clear command both hold the counters at the start of a cycle. Counting restarts at a fixed phase when either is released.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With constant presets, consecutive `div_o` pulses are exactly P·B + A clocks apart, where A and B are the effective values of R4 to R6.
- R2: `div_o` is high for exactly one clock per division cycle.
- R3: `mod_sel_i` = 0 selects P = 2^K_LOG2 and `mod_sel_i` = 1 selects P = 2^(K_LOG2+1).
- R4: Only the low A_USED bits of `swallow_i` are used; the bits above them have no effect on the period.
- R5: A `main_i` value below 3 is treated as 3.
- R6: A swallow value larger than the effective B is treated as equal to B.
- R7: New preset values take effect only at the start of the next division cycle; the period that is running completes with the old values.
- R8: While `pwr_down_i` is high, `div_o` and `mod_ctrl_o` stay low. After release, the first pulse comes exactly P·B + A clocks later, counting the first rising edge with `pwr_down_i` low as clock 1.
- R9: A one-clock `cnt_clr_i` restarts the division cycle. The first pulse after release comes exactly P·B + A clocks later, with no alignment error.
- R10: In each division cycle, `mod_ctrl_o` is high for exactly A·(P+1) clocks and low for the other (B−A)·P clocks. The line changes only at prescaler cycle boundaries.
- R11: During synchronous reset `div_o` is low. The first pulse after reset release comes exactly P·B + A clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock (oscillator rate) |
| rst_i | input | 1 | Synchronous active-high reset |
| pwr_down_i | input | 1 | Power-down: holds the divider, forces outputs low |
| cnt_clr_i | input | 1 | Counter clear: restarts the division cycle |
| mod_sel_i | input | 1 | Base modulus select (0: 2^K_LOG2, 1: 2^(K_LOG2+1)) |
| swallow_i | input | A_WIDTH | Swallow preset A |
| main_i | input | B_WIDTH | Main preset B |
| div_o | output | 1 | One-clock pulse per division cycle |
| mod_ctrl_o | output | 1 | High while the prescaler divides by P+1 |

## Verification
A swallow counter in the wrong state shifts the period by a multiple of one clock, and the error shows in the very next pulse interval. It also changes how many clocks `mod_ctrl_o` stays high within that interval. Each of these is measured over one full period. A main counter or prescaler fault moves the period by multiples of P, so it also shows within one division cycle. A fault in preset capture shows as a period that is cut short or lengthened in the cycle during which the presets change. A fault in the restart logic shows as an error in the first pulse after a clear, a power-down or a reset.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    // Default geometry of the high-band instance
    localparam int DEF_K_LOG2  = 5;   // base modulus 32, doubled 64
    localparam int DEF_A_WIDTH = 7;
    localparam int DEF_B_WIDTH = 11;
    localparam int MAIN_MIN    = 3;

    // Which modulus the prescaler runs in this prescaler cycle
    typedef enum logic {
        SPAN_BASE  = 1'b0,
        SPAN_PLUS1 = 1'b1
    } span_e;

    // Terminal count of one prescaler cycle: base-1, plus one when swallowing
    function automatic int unsigned pre_last(input int unsigned k_log2,
                                             input logic big,
                                             input span_e span);
        int unsigned base;
        base = big ? (32'd1 << (k_log2 + 1)) : (32'd1 << k_log2);
        return base - 1 + ((span == SPAN_PLUS1) ? 1 : 0);
    endfunction

endpackage

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler
    import fdiv_pkg::*;
#(
    parameter int K_LOG2 = DEF_K_LOG2
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  hold_i,
    input  logic  big_i,
    input  span_e span_i,
    output logic  tc_o
);
    localparam int PC_W = K_LOG2 + 2;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] last;

    always_comb begin
        last = PC_W'(pre_last(K_LOG2, big_i, span_i));
        tc_o = (pc_q == last);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_i || tc_o) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end
endmodule

// File: rtl/fdiv_swallow_ctr.sv
module fdiv_swallow_ctr
    import fdiv_pkg::*;
#(
    parameter int A_WIDTH = DEF_A_WIDTH
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [A_WIDTH-1:0] preset_i,
    output span_e              span_o
);
    logic [A_WIDTH-1:0] rem_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || load_i) begin
            rem_q <= preset_i;
        end else if (step_i && (rem_q != '0)) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign span_o = (rem_q != '0) ? SPAN_PLUS1 : SPAN_BASE;
endmodule

// File: rtl/fdiv_main_ctr.sv
module fdiv_main_ctr
    import fdiv_pkg::*;
#(
    parameter int B_WIDTH = DEF_B_WIDTH
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [B_WIDTH-1:0] preset_i,
    output logic               last_o
);
    logic [B_WIDTH-1:0] rem_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || load_i) begin
            rem_q <= preset_i;
        end else if (step_i) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign last_o = (rem_q == B_WIDTH'(1));
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
    import fdiv_pkg::*;
#(
    parameter int K_LOG2  = DEF_K_LOG2,
    parameter int A_WIDTH = DEF_A_WIDTH,
    parameter int A_USED  = DEF_A_WIDTH,
    parameter int B_WIDTH = DEF_B_WIDTH
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               pwr_down_i,
    input  logic               cnt_clr_i,
    input  logic               mod_sel_i,
    input  logic [A_WIDTH-1:0] swallow_i,
    input  logic [B_WIDTH-1:0] main_i,
    output logic               div_o,
    output logic               mod_ctrl_o
);
    localparam int CMP_W = (A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH;

    logic               hold;
    logic               pre_tc;
    logic               b_last;
    logic               cycle_end;
    logic               reload;
    span_e              span;
    logic               big_q;
    logic               div_q;
    logic [A_WIDTH-1:0] a_masked;
    logic [A_WIDTH-1:0] a_eff;
    logic [B_WIDTH-1:0] b_eff;
    logic [CMP_W-1:0]   a_cmp;
    logic [CMP_W-1:0]   b_cmp;

    // Ignore the swallow bits above A_USED
    generate
        if (A_USED < A_WIDTH) begin : g_mask
            assign a_masked = {{(A_WIDTH-A_USED){1'b0}}, swallow_i[A_USED-1:0]};
        end else begin : g_nomask
            assign a_masked = swallow_i;
        end
    endgenerate

    // Clamp main to its legal floor, swallow to main
    always_comb begin
        b_eff = (main_i < B_WIDTH'(MAIN_MIN)) ? B_WIDTH'(MAIN_MIN) : main_i;
        a_cmp = CMP_W'(a_masked);
        b_cmp = CMP_W'(b_eff);
        a_eff = (a_cmp > b_cmp) ? A_WIDTH'(b_cmp) : a_masked;
    end

    assign hold      = pwr_down_i || cnt_clr_i;
    assign cycle_end = pre_tc && b_last;
    assign reload    = hold || cycle_end;

    // Modulus select is captured with the counter presets
    always_ff @(posedge clk_i) begin
        if (rst_i || reload) begin
            big_q <= mod_sel_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || hold) begin
            div_q <= 1'b0;
        end else begin
            div_q <= cycle_end;
        end
    end

    fdiv_prescaler #(.K_LOG2(K_LOG2)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .hold_i (hold),
        .big_i  (big_q),
        .span_i (span),
        .tc_o   (pre_tc)
    );

    fdiv_swallow_ctr #(.A_WIDTH(A_WIDTH)) u_swc (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (reload),
        .step_i   (pre_tc),
        .preset_i (a_eff),
        .span_o   (span)
    );

    fdiv_main_ctr #(.B_WIDTH(B_WIDTH)) u_mnc (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (reload),
        .step_i   (pre_tc),
        .preset_i (b_eff),
        .last_o   (b_last)
    );

    assign div_o      = div_q;
    assign mod_ctrl_o = (span == SPAN_PLUS1) && !pwr_down_i;
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker (
    input logic clk_i,
    input logic rst_i,
    input logic pwr_down_i,
    input logic hold,
    input logic pre_tc,
    input logic b_last,
    input logic swallow_act,
    input logic div_o
);
    assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        div_o |=> !div_o);

    assert_pd_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        pwr_down_i |=> !div_o);

    assert_reset_quiet_R11: assert property (@(posedge clk_i)
        rst_i |=> !div_o);

    assert_pulse_on_last_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        div_o |-> $past(b_last));

    assert_mc_boundary_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(swallow_act) |-> $past(pre_tc || hold));
endmodule

bind pulse_swallow_divider fdiv_checker u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .pwr_down_i  (pwr_down_i),
    .hold        (hold),
    .pre_tc      (pre_tc),
    .b_last      (b_last),
    .swallow_act (span == fdiv_pkg::SPAN_PLUS1),
    .div_o       (div_o)
);

// File: tb/pulse_swallow_divider_tb.sv
module pulse_swallow_divider_tb_top;
    localparam int K  = 3;   // 8 / 16
    localparam int AW = 7;
    localparam int AU = 4;
    localparam int BW = 6;

    logic          clk = 1'b0;
    logic          rst, pd, clr, sel;
    logic [AW-1:0] a_in;
    logic [BW-1:0] b_in;
    logic          div_o, mc_o;
    int            total = 0;
    int            bad   = 0;
    bit            done  = 0;

    always #10 clk = ~clk;

    pulse_swallow_divider #(.K_LOG2(K), .A_WIDTH(AW), .A_USED(AU), .B_WIDTH(BW)) dut_i (
        .clk_i(clk), .rst_i(rst), .pwr_down_i(pd), .cnt_clr_i(clr),
        .mod_sel_i(sel), .swallow_i(a_in), .main_i(b_in),
        .div_o(div_o), .mod_ctrl_o(mc_o)
    );

    function automatic int eff_b(int b);
        return (b < 3) ? 3 : b;
    endfunction
    function automatic int eff_a(int a, int b);
        int am = a % (1 << AU);
        return (am > eff_b(b)) ? eff_b(b) : am;
    endfunction
    function automatic int pmod(int s);
        return s ? (2 << K) : (1 << K);
    endfunction
    function automatic int exp_n(int a, int b, int s);
        return pmod(s) * eff_b(b) + eff_a(a, b);
    endfunction

    task automatic check(int act, int exp, string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count clocks until the next sampled pulse; also count mod_ctrl high samples
    task automatic wait_pulse(output int cnt, output int mc_hi);
        cnt = 0; mc_hi = 0;
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); @(negedge clk);
            cnt++;
            if (mc_o) mc_hi++;
            if (div_o) return;
        end
        cnt = -1;
    endtask

    task automatic apply(int a, int b, int s);
        a_in = AW'(a); b_in = BW'(b); sel = s[0];
    endtask

    task automatic clear_pulse();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic run_case(int a, int b, int s, string req);
        int n, m, n2, m2;
        apply(a, b, s);
        clear_pulse();
        wait_pulse(n, m);
        check(n, exp_n(a, b, s), {req, " R9 first pulse after clear"});
        @(posedge clk); @(negedge clk);
        check(int'(div_o), 0, "R2 pulse width");
        wait_pulse(n2, m2);
        if (n2 > 0) begin
            n2++; if (mc_o) m2++;   // sample skipped above was low and belongs to the interval
        end
        check(n2, exp_n(a, b, s), {req, " R1 interval"});
        check(m2, eff_a(a, b) * (pmod(s) + 1), "R10 modulus-control high clocks");
    endtask

    initial begin
        #(20 * 190000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, m;
        rst = 1'b1; pd = 1'b0; clr = 1'b0;
        apply(5, 10, 0);
        repeat (3) @(negedge clk);
        check(int'(div_o), 0, "R11 output low in reset");
        rst = 1'b0;
        wait_pulse(n, m);
        check(n, exp_n(5, 10, 0), "R11 first pulse after reset");

        // R1/R3/R10 sweep over both moduli, many B, several A
        for (int s = 0; s < 2; s++) begin
            for (int b = 3; b < 64; b += ((b < 8) ? 1 : 13)) begin
                run_case(0, b, s, "R3");
                run_case(1, b, s, "R3");
                run_case(b / 2, b, s, "R1");
                run_case((b < 15) ? b : 15, b, s, "R1");
            end
        end

        // R4: upper swallow bits ignored
        run_case(7'h3B, 20, 0, "R4");
        run_case(7'h70, 20, 1, "R4");
        // R5: main below floor
        run_case(0, 0, 0, "R5");
        run_case(2, 1, 1, "R5");
        run_case(1, 2, 0, "R5");
        // R6: swallow above main
        run_case(9, 5, 0, "R6");
        run_case(15, 3, 1, "R6");

        // R7: presets changed mid-cycle
        begin
            int cnt;
            apply(3, 6, 0);
            clear_pulse();
            wait_pulse(n, m);
            cnt = 0;
            for (int i = 0; i < 4000; i++) begin
                @(posedge clk); @(negedge clk);
                cnt++;
                if (cnt == 10) apply(2, 4, 1);
                if (div_o) break;
            end
            check(cnt, exp_n(3, 6, 0), "R7 running period keeps old presets");
            wait_pulse(n, m);
            check(n, exp_n(2, 4, 1), "R7 next period uses new presets");
        end

        // R8: power-down
        begin
            int hi = 0;
            apply(4, 9, 1);
            clear_pulse();
            wait_pulse(n, m);
            repeat (7) @(negedge clk);
            pd = 1'b1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (div_o || mc_o) hi++;
            end
            check(hi, 0, "R8 outputs low during power-down");
            pd = 1'b0;
            wait_pulse(n, m);
            check(n, exp_n(4, 9, 1), "R8 first pulse after power-down");
        end

        // R9: clear in the middle of a period
        apply(6, 11, 0);
        clear_pulse();
        repeat (30) @(negedge clk);
        clear_pulse();
        wait_pulse(n, m);
        check(n, exp_n(6, 11, 0), "R9 mid-period clear realigns");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule